// File: doc/BRIEF.md
# Cascaded Reloadable Byte Timer Unit

This block is a small timing resource for a microcontroller-style subsystem. A free-running divide-by-16 base tick drives two 8-bit prescalers. The first prescaler's underflows clock two 8-bit timers (A and B). The second prescaler's underflows clock a third timer (C). Every stage counts down. When a stage ticks while it is at zero, it takes its reload value minus one (modulo 256) and passes one underflow pulse on. As a result, a reload value of r gives a period of r ticks, and a reload value of 0 gives a period of 256 ticks.

Each timer underflow sets a request bit, and the request bit stays set until software writes it low. Each request bit sits directly above its enable bit. The requests and enables for timers A and B live in the interrupt-control register. The request and enable for timer C live in the timer-control register, which also holds the stop bit and the mode field for the second prescaler chain. A single registered interrupt output goes high when any request meets its enable and the interrupt mask input is low. Software reaches all seven registers through a byte-wide register bus with a 3-bit offset.

Top module: `tmr_unit`

## Requirements
- R1: A write to offsets 1..5 (1 = prescaler P, 2 = timer A, 3 = timer B, 4 = prescaler Q, 5 = timer C) loads both the current count and the reload value of that stage. A read returns the current count on `bus_rdata_o` one cycle after the read strobe. Offset 6 reads back interrupt control, offset 7 reads back timer control, and offset 0 reads 0.
- R2: The prescalers change only on a base tick, which occurs once every 16 clock cycles.
- R3: On each tick a stage decrements. A tick that arrives while the stage is at 0 loads (reload − 1) mod 256 and emits one underflow pulse.
- R4: A reload value of 0 gives a period of 256 ticks (4096 clocks for prescaler P).
- R5: Prescaler P's underflows clock timers A and B. Prescaler Q's underflows clock timer C.
- R6: An underflow of timer A sets interrupt-control bit 5, timer B sets bit 3, and timer C sets timer-control bit 7. These bits stay set until a write clears them.
- R7: `irq_o` is a register that is high one cycle after `irq_mask_i` is low and at least one of these pairs is set: (IC bit 5, IC bit 4), (IC bit 3, IC bit 2), (TC bit 7, TC bit 6).
- R8: Prescaler Q and timer C are frozen while TC bit 5 is 1 or TC bits 3:2 are not 00. In that state a read of either returns the same value over time.
- R9: After reset, every count, reload value, control register, `bus_rdata_o` and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| irq_mask_i | input | 1 | Global interrupt mask, 1 blocks `irq_o` |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Read data is due one edge after the strobe, so each sample is taken at the falling edge that follows that edge. `irq_o` is due one edge after its inputs change, and the bench samples exactly that falling edge, having first confirmed the old value is still present. Each underflow pulse is registered, so a request bit lands one cycle after its counter wraps. The bench therefore reads request bits only after the wrap has been seen. For counter sequences, the bench reads every cycle and compares each new value and the cycle gap between changes against the arithmetic expectation. It skips the first, partial interval, because the base tick phase is unknown.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register offsets on the bus
  localparam int OFS_PRE_P = 1;
  localparam int OFS_TMR_A = 2;
  localparam int OFS_TMR_B = 3;
  localparam int OFS_PRE_Q = 4;
  localparam int OFS_TMR_C = 5;
  localparam int OFS_ICTL  = 6;
  localparam int OFS_TCTL  = 7;
  // stage indices (offset - 1)
  localparam int STG_PRE_P = 0;
  localparam int STG_TMR_A = 1;
  localparam int STG_TMR_B = 2;
  localparam int STG_PRE_Q = 3;
  localparam int STG_TMR_C = 4;
  localparam int N_STG     = 5;
  // control bit positions; each enable sits one below its request
  localparam int RQ_A      = 5;
  localparam int RQ_B      = 3;
  localparam int RQ_C      = 7;
  localparam int TC_STOP   = 5;
  localparam int TC_MODE_LO = 2;
endpackage

// File: rtl/tmr_prediv.sv
module tmr_prediv #(
  parameter int DIV_W = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign tick_o = &cnt;
endmodule

// File: rtl/tmr_stage.sv
module tmr_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt;
  logic [W-1:0] rel;
  logic         wrap;

  assign wrap = tick_i && (cnt == '0) && !ld_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      rel  <= '0;
      uf_o <= 1'b0;
    end else begin
      uf_o <= wrap;
      if (ld_i) begin
        cnt <= ld_val_i;
        rel <= ld_val_i;
      end else if (tick_i) begin
        // reload minus one wraps naturally: 0 gives all ones, period 2**W
        cnt <= (cnt == '0) ? rel - 1'b1 : cnt - 1'b1;
      end
    end
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  input  logic              irq_mask_i,
  output logic [W-1:0]      bus_rdata_o,
  output logic              irq_o
);
  logic             base_tick;
  logic             wr_en;
  logic             wr_ic;
  logic             wr_tc;
  logic             x_run;
  logic [N_STG-1:0] stg_ld;
  logic [N_STG-1:0] stg_tick;
  logic [N_STG-1:0] stg_uf;
  logic [W-1:0]     cnt_val [N_STG];
  logic [W-1:0]     ic;
  logic [W-1:0]     tc;
  logic [W-1:0]     ic_set;
  logic [W-1:0]     tc_set;
  logic [W-1:0]     rd_mux;

  tmr_prediv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .tick_o(base_tick)
  );

  assign wr_en = bus_sel_i && bus_we_i;
  assign wr_ic = wr_en && (bus_addr_i == ADDR_W'(OFS_ICTL));
  assign wr_tc = wr_en && (bus_addr_i == ADDR_W'(OFS_TCTL));
  assign x_run = !tc[TC_STOP] && (tc[TC_MODE_LO+1:TC_MODE_LO] == 2'b00);

  always_comb begin
    stg_tick            = '0;
    stg_tick[STG_PRE_P] = base_tick;
    stg_tick[STG_TMR_A] = stg_uf[STG_PRE_P];
    stg_tick[STG_TMR_B] = stg_uf[STG_PRE_P];
    stg_tick[STG_PRE_Q] = base_tick && x_run;
    stg_tick[STG_TMR_C] = stg_uf[STG_PRE_Q] && x_run;
  end

  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    assign stg_ld[g] = wr_en && (bus_addr_i == ADDR_W'(g + 1));
    tmr_stage #(.W(W)) u_stage (
      .clk(clk), .rst(rst),
      .tick_i(stg_tick[g]), .ld_i(stg_ld[g]), .ld_val_i(bus_wdata_i),
      .cnt_o(cnt_val[g]), .uf_o(stg_uf[g])
    );
  end

  always_comb begin
    ic_set = '0;
    tc_set = '0;
    ic_set[RQ_A] = stg_uf[STG_TMR_A];
    ic_set[RQ_B] = stg_uf[STG_TMR_B];
    tc_set[RQ_C] = stg_uf[STG_TMR_C];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_STG; i++)
      if (bus_addr_i == ADDR_W'(i + 1)) rd_mux = cnt_val[i];
    if (bus_addr_i == ADDR_W'(OFS_ICTL)) rd_mux = ic;
    if (bus_addr_i == ADDR_W'(OFS_TCTL)) rd_mux = tc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ic          <= '0;
      tc          <= '0;
      bus_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      ic <= (wr_ic ? bus_wdata_i : ic) | ic_set;
      tc <= (wr_tc ? bus_wdata_i : tc) | tc_set;
      if (bus_sel_i && !bus_we_i) bus_rdata_o <= rd_mux;
      irq_o <= !irq_mask_i &&
               ((ic[RQ_A] && ic[RQ_A-1]) ||
                (ic[RQ_B] && ic[RQ_B-1]) ||
                (tc[RQ_C] && tc[RQ_C-1]));
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         irq_mask_i,
  input logic         irq_o,
  input logic [W-1:0] ic,
  input logic [W-1:0] tc,
  input logic         wr_ic,
  input logic         wr_tc,
  input logic         base_tick,
  input logic         ld_p,
  input logic         ld_c,
  input logic [W-1:0] cnt_p,
  input logic [W-1:0] cnt_c
);
  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_mask_i && ic[5] && ic[4]) |=> irq_o);
  // R7
  irq_block_chk: assert property (@(posedge clk) disable iff (rst)
    irq_mask_i |=> !irq_o);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ic[5] && !wr_ic) |=> ic[5]);
  // R6
  reqc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tc[7] && !wr_tc) |=> tc[7]);
  // R8
  c_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (tc[5] && !wr_tc && !ld_c) |=> $stable(cnt_c));
  // R2
  p_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!base_tick && !ld_p) |=> $stable(cnt_p));
  // R9
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!irq_o && ic == '0 && tc == '0));
endmodule

bind tmr_unit tmr_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .irq_mask_i(irq_mask_i), .irq_o(irq_o),
  .ic(ic), .tc(tc), .wr_ic(wr_ic), .wr_tc(wr_tc), .base_tick(base_tick),
  .ld_p(stg_ld[0]), .ld_c(stg_ld[4]), .cnt_p(cnt_val[0]), .cnt_c(cnt_val[4])
);

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       mask = 1'b1;
  logic [7:0] rdata;
  logic       irq;
  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  tmr_unit u_dut (
    .clk(clk), .rst(rst), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .irq_mask_i(mask), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; v = rdata;
  endtask

  // load a stage, then read it every cycle and check every step and gap (R1, R3)
  task automatic run_seq(input logic [2:0] a, input logic [7:0] r, input int ntr, input string req);
    logic [7:0] prev;
    logic [7:0] expv;
    int cyc = 0;
    int last = -1;
    int tr = 0;
    wr(a, r);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); prev = rdata;
    chk(prev == r, "R1 load", prev, r);
    while (tr < ntr && cyc < 3000) begin
      @(negedge clk); cyc++;
      if (rdata != prev) begin
        expv = (prev == 8'd0) ? r - 8'd1 : prev - 8'd1;
        chk(rdata == expv, req, rdata, expv);
        if (last >= 0) chk(cyc - last == 16, "R2/R5 step gap", cyc - last, 16);
        last = cyc; prev = rdata; tr++;
      end
    end
    sel = 1'b0;
    chk(tr == ntr, "R3 transitions", tr, ntr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] v2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rdata == 8'd0, "R9 rdata", rdata, 0);
    chk(irq == 1'b0, "R9 irq", irq, 0);
    rd(3'd6, v); chk(v == 8'd0, "R9 ictl", v, 0);
    rd(3'd2, v); chk(v == 8'd0, "R9 timer A", v, 0);

    // R1 register map
    rd(3'd0, v); chk(v == 8'd0, "R1 offset 0", v, 0);
    wr(3'd6, 8'h14); rd(3'd6, v); chk((v & 8'h57) == 8'h14, "R1 ictl readback", v, 8'h14);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h00);

    // R3 prescaler P sweep, two wraps each
    for (int r = 2; r < 8; r++) run_seq(3'd1, 8'(r), 2 * r + 1, "R3 prescaler P");

    // R4 zero reload: 256 ticks between visits to 255
    begin
      int cyc = 0;
      int first = -1;
      int gap = 0;
      logic [7:0] prev;
      wr(3'd1, 8'd0);
      sel = 1'b1; we = 1'b0; addr = 3'd1;
      @(negedge clk); prev = rdata;
      while (gap == 0 && cyc < 10000) begin
        @(negedge clk); cyc++;
        if (rdata != prev && rdata == 8'hFF) begin
          if (first < 0) first = cyc; else gap = cyc - first;
        end
        prev = rdata;
      end
      sel = 1'b0;
      chk(gap == 4096, "R4 zero period", gap, 4096);
    end

    // R5/R6 timers A and B clocked by prescaler P (P=1 gives one underflow per base tick)
    wr(3'd1, 8'd1);
    repeat (40) @(negedge clk);
    for (int r = 2; r < 6; r++) begin
      wr(3'd6, 8'h00);
      run_seq(3'd2, 8'(r), r + 1, "R5 timer A");
      repeat (2) @(negedge clk);
      rd(3'd6, v); chk(v[5] == 1'b1, "R6 timer A request", v[5], 1);
      repeat (20) @(negedge clk);
      rd(3'd6, v); chk(v[5] == 1'b1, "R6 request sticky", v[5], 1);
    end
    for (int r = 2; r < 6; r++) begin
      wr(3'd6, 8'h00);
      run_seq(3'd3, 8'(r), r + 1, "R5 timer B");
      repeat (2) @(negedge clk);
      rd(3'd6, v); chk(v[3] == 1'b1, "R6 timer B request", v[3], 1);
    end
    wr(3'd2, 8'd250);
    wr(3'd3, 8'd250);
    repeat (40) @(negedge clk);
    wr(3'd6, 8'h00);
    rd(3'd6, v); chk((v & 8'h28) == 8'h00, "R6 clear by write", v, 0);

    // R5/R6 timer C clocked by prescaler Q
    wr(3'd7, 8'h00);
    wr(3'd4, 8'd1);
    repeat (40) @(negedge clk);
    for (int r = 2; r < 5; r++) begin
      wr(3'd7, 8'h00);
      run_seq(3'd5, 8'(r), r + 1, "R5 timer C");
      repeat (2) @(negedge clk);
      rd(3'd7, v); chk(v[7] == 1'b1, "R6 timer C request", v[7], 1);
    end

    // R7 interrupt combine, mask and latency
    mask = 1'b0;
    wr(3'd7, 8'h00);
    @(negedge clk);
    chk(irq == 1'b0, "R7 idle", irq, 0);
    wr(3'd6, 8'h30);
    chk(irq == 1'b0, "R7 not yet", irq, 0);
    @(negedge clk); chk(irq == 1'b1, "R7 A raise", irq, 1);
    mask = 1'b1;
    @(negedge clk); chk(irq == 1'b0, "R7 masked", irq, 0);
    mask = 1'b0;
    @(negedge clk); chk(irq == 1'b1, "R7 unmasked", irq, 1);
    wr(3'd6, 8'h20);
    @(negedge clk); chk(irq == 1'b0, "R7 enable off", irq, 0);
    wr(3'd6, 8'h0C);
    @(negedge clk); chk(irq == 1'b1, "R7 B raise", irq, 1);
    wr(3'd6, 8'h08);
    @(negedge clk); chk(irq == 1'b0, "R7 B enable off", irq, 0);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'hC0);
    @(negedge clk); chk(irq == 1'b1, "R7 C raise", irq, 1);
    mask = 1'b1;

    // R8 timer C chain frozen by stop bit and by non-plain mode
    wr(3'd7, 8'h20);
    rd(3'd5, v); repeat (100) @(negedge clk); rd(3'd5, v2);
    chk(v == v2, "R8 stop freezes C", v2, v);
    rd(3'd4, v); repeat (50) @(negedge clk); rd(3'd4, v2);
    chk(v == v2, "R8 stop freezes Q", v2, v);
    wr(3'd7, 8'h08);
    rd(3'd5, v); repeat (100) @(negedge clk); rd(3'd5, v2);
    chk(v == v2, "R8 mode freezes C", v2, v);
    wr(3'd7, 8'h00);
    rd(3'd5, v); repeat (100) @(negedge clk); rd(3'd5, v2);
    chk(v != v2, "R8 plain mode runs", v2, v);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule